// File: doc/BRIEF.md
# Flash Status Register and Block Protection Unit

This unit keeps the eight-bit status word of a serial flash memory. It tracks the busy indication, runs the write-enable latch, and holds the protection fields. These are the three-bit protect level, the top/bottom selector and the status-write lock. All of them are kept in plain registers. Decoded command pulses from the serial front end drive it: enable writes, disable writes, and write the status byte. The status-write pulse comes with its data byte and a flag that says exactly one data byte was framed.

The unit gates each status write on the latch, the busy state, the framing flag, the lock bit and the write-protect pin. An accepted status write starts a self-timed busy window. When the window ends, the write-enable latch clears. An external completion pulse from the erase/program engine clears it in the same way.

In parallel, the unit decodes the protect fields into a protected region at the top or the bottom of the array. It reports whether the current query address falls inside that region, and whether a full-array erase is allowed.

Top module: `flash_status_protect`

## Requirements
- R1: After reset the status byte reads 00h, no query address is protected and full-array erase is allowed.
- R2: Status byte layout: bit0 busy, bit1 write-enable, bits 4..2 protect level (bit2 is the LSB), bit5 bottom-select, bit6 always 0, bit7 lock. Busy is 1 while `op_busy` is high or while a status-write window runs.
- R3: The cycle after `wren_pulse`, write-enable is 1. The cycle after `wrdis_pulse`, it is 0. When both pulses arrive together, disable wins.
- R4: The cycle after `op_done`, write-enable is 0. This beats a simultaneous `wren_pulse`.
- R5: A status write is accepted only when all of the following hold: write-enable is 1, busy is 0, `swr_one_byte` is 1, and the pair (lock = 1, `wp_n` = 0) does not occur. A rejected write changes no status bit, and write-enable keeps its value.
- R6: An accepted write loads bits 7, 5, 4, 3 and 2 from the data byte. Data bits 0, 1 and 6 have no effect.
- R7: After an accepted write, busy reads 1 for exactly `BUSY_CYCLES` clock cycles, starting the next cycle. Write-enable reads 0 from the cycle in which busy drops.
- R8: With bottom-select 0, levels 1, 2 and 3 protect the top 1/8, 1/4 and 1/2 of the array (the top 64 KB, 128 KB and 256 KB of 512 KB).
- R9: With bottom-select 1, the same levels protect the bottom 1/8, 1/4 and 1/2 of the array.
- R10: Level 0 protects nothing. Any level with bit 4 set protects the whole array, whatever bottom-select is.
- R11: `chip_erase_ok` is 1 exactly when the protect level is 0.
- R12: Only the low `ADDR_W` (19) bits of `query_addr` are compared. The upper bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_pulse | input | 1 | Decoded write-enable command |
| wrdis_pulse | input | 1 | Decoded write-disable command |
| swr_pulse | input | 1 | Decoded status-write command at frame end |
| swr_data | input | 8 | Status-write data byte |
| swr_one_byte | input | 1 | Exactly one data byte was framed |
| wp_n | input | 1 | Write-protect pin level, active low |
| op_busy | input | 1 | Erase/program engine busy |
| op_done | input | 1 | Erase/program completion pulse |
| query_addr | input | QADDR_W (24) | Address under test |
| status_byte | output | 8 | Status word |
| addr_protected | output | 1 | Query address is inside the protected region |
| chip_erase_ok | output | 1 | Full-array erase is permitted |

## Verification
The checker tests the following properties on every cycle:
- the write-enable latch responds to its set, clear and completion pulses;
- the protection fields never change without a status-write pulse, and never change while the lock and pin forbid it;
- an accepted write raises busy;
- bit 6 stays 0;
- a level with bit 4 set protects every address, and erase permission excludes protection.

Only the bench scenarios can show the rest:
- the exact length of the busy window and the write-enable clear at its end;
- the way data bits are mapped;
- the region boundaries of every level and bottom-select combination, which the bench sweeps at each 4 KB edge, with the upper address bits set as well.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    localparam int SR_BUSY = 0;
    localparam int SR_WEN  = 1;
    localparam int SR_LVL0 = 2;
    localparam int SR_BOT  = 5;
    localparam int SR_RSVD = 6;
    localparam int SR_LOCK = 7;

    typedef struct packed {
        logic       lock;
        logic       bottom;
        logic [2:0] level;
    } prot_fields_t;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_PART = 2'd1,
        PK_ALL  = 2'd2
    } prot_kind_e;

    function automatic prot_kind_e classify(input logic [2:0] level);
        if (level[2])
            return PK_ALL;
        else if (level[1:0] == 2'b00)
            return PK_NONE;
        else
            return PK_PART;
    endfunction

    // Which of the three top address bits select the region for a partial level.
    function automatic logic [2:0] region_mask(input logic [1:0] lvl);
        case (lvl)
            2'b01:   return 3'b111;
            2'b10:   return 3'b110;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic part_hit(input logic [2:0] msb3, input logic bottom,
                                      input logic [1:0] lvl);
        logic [2:0] want;
        want = bottom ? 3'b000 : 3'b111;
        return ((msb3 ^ want) & region_mask(lvl)) == 3'b000;
    endfunction

    function automatic logic [7:0] pack_status(input prot_fields_t f, input logic wen,
                                               input logic busy);
        logic [7:0] s;
        s = '0;
        s[SR_BUSY]            = busy;
        s[SR_WEN]             = wen;
        s[SR_LVL0 +: 3]       = f.level;
        s[SR_BOT]             = f.bottom;
        s[SR_RSVD]            = 1'b0;
        s[SR_LOCK]            = f.lock;
        return s;
    endfunction

    function automatic prot_fields_t unpack_fields(input logic [7:0] d);
        prot_fields_t f;
        f.lock   = d[SR_LOCK];
        f.bottom = d[SR_BOT];
        f.level  = d[SR_LVL0 +: 3];
        return f;
    endfunction

endpackage

// File: rtl/fsp_wel.sv
module fsp_wel (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    input  logic auto_clr,
    output logic wen
);
    always_ff @(posedge clk) begin
        if (rst)
            wen <= 1'b0;
        else if (auto_clr || clr_req)
            wen <= 1'b0;
        else if (set_req)
            wen <= 1'b1;
    end
endmodule

// File: rtl/fsp_busy_timer.sv
module fsp_busy_timer #(
    parameter int CYCLES = 1800000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - ONE;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == ONE);
endmodule

// File: rtl/fsp_status_regs.sv
module fsp_status_regs
    import fsp_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_req,
    input  logic         wr_single,
    input  logic [7:0]   wr_data,
    input  logic         wen,
    input  logic         busy,
    input  logic         wp_n,
    output prot_fields_t fields,
    output logic         accept
);
    logic locked;

    assign locked = fields.lock && !wp_n;
    assign accept = wr_req && wr_single && wen && !busy && !locked;

    always_ff @(posedge clk) begin
        if (rst)
            fields <= '0;
        else if (accept)
            fields <= unpack_fields(wr_data);
    end
endmodule

// File: rtl/fsp_protect_decode.sv
module fsp_protect_decode
    import fsp_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] addr,
    input  prot_fields_t      fields,
    output logic              hit,
    output logic              chip_ok
);
    logic [2:0] msb3;
    prot_kind_e kind;

    assign msb3 = addr[ADDR_W-1 -: 3];
    assign kind = classify(fields.level);

    always_comb begin
        case (kind)
            PK_ALL:  hit = 1'b1;
            PK_PART: hit = part_hit(msb3, fields.bottom, fields.level[1:0]);
            default: hit = 1'b0;
        endcase
    end

    assign chip_ok = (kind == PK_NONE);
endmodule

// File: rtl/flash_status_protect.sv
module flash_status_protect
    import fsp_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int QADDR_W     = 24,
    parameter int BUSY_CYCLES = 1800000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wren_pulse,
    input  logic               wrdis_pulse,
    input  logic               swr_pulse,
    input  logic [7:0]         swr_data,
    input  logic               swr_one_byte,
    input  logic               wp_n,
    input  logic               op_busy,
    input  logic               op_done,
    input  logic [QADDR_W-1:0] query_addr,
    output logic [7:0]         status_byte,
    output logic               addr_protected,
    output logic               chip_erase_ok
);
    prot_fields_t fields;
    logic         wen;
    logic         busy;
    logic         tmr_busy;
    logic         tmr_done;
    logic         accept;

    assign busy = op_busy || tmr_busy;

    fsp_wel u_wel (
        .clk      (clk),
        .rst      (rst),
        .set_req  (wren_pulse),
        .clr_req  (wrdis_pulse),
        .auto_clr (op_done || tmr_done),
        .wen      (wen)
    );

    fsp_status_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (swr_pulse),
        .wr_single (swr_one_byte),
        .wr_data   (swr_data),
        .wen       (wen),
        .busy      (busy),
        .wp_n      (wp_n),
        .fields    (fields),
        .accept    (accept)
    );

    fsp_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    fsp_protect_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (query_addr[ADDR_W-1:0]),
        .fields  (fields),
        .hit     (addr_protected),
        .chip_ok (chip_erase_ok)
    );

    assign status_byte = pack_status(fields, wen, busy);
endmodule

// File: rtl/flash_status_protect_chk.sv
module flash_status_protect_chk #(
    parameter int QADDR_W = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               wren_pulse,
    input logic               wrdis_pulse,
    input logic               swr_pulse,
    input logic               swr_one_byte,
    input logic               wp_n,
    input logic               op_busy,
    input logic               op_done,
    input logic [7:0]         status_byte,
    input logic               addr_protected,
    input logic               chip_erase_ok
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !status_byte[6]);
    assert_ext_busy_R2: assert property (@(posedge clk) disable iff (rst)
        op_busy |-> status_byte[0]);
    assert_wrdis_clears_R3: assert property (@(posedge clk) disable iff (rst)
        wrdis_pulse |=> !status_byte[1]);
    assert_wren_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (wren_pulse && !wrdis_pulse && !op_done && !status_byte[0]) |=> status_byte[1]);
    assert_done_clears_R4: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !status_byte[1]);
    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (swr_pulse && status_byte[7] && !wp_n) |=> $stable(status_byte[7:2]));
    assert_no_stray_write_R5: assert property (@(posedge clk) disable iff (rst)
        !swr_pulse |=> $stable(status_byte[7:2]));
    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (swr_pulse && swr_one_byte && status_byte[1] && !status_byte[0]
         && (!status_byte[7] || wp_n)) |=> status_byte[0]);
    assert_full_protect_R10: assert property (@(posedge clk) disable iff (rst)
        status_byte[4] |-> addr_protected);
    assert_erase_excl_R11: assert property (@(posedge clk) disable iff (rst)
        chip_erase_ok |-> !addr_protected);
endmodule

bind flash_status_protect flash_status_protect_chk #(.QADDR_W(QADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wren_pulse     (wren_pulse),
    .wrdis_pulse    (wrdis_pulse),
    .swr_pulse      (swr_pulse),
    .swr_one_byte   (swr_one_byte),
    .wp_n           (wp_n),
    .op_busy        (op_busy),
    .op_done        (op_done),
    .status_byte    (status_byte),
    .addr_protected (addr_protected),
    .chip_erase_ok  (chip_erase_ok)
);

// File: tb/tb_flash_status_protect.sv
module tb_flash_status_protect;
    localparam int BUSY = 5;
    localparam int AW   = 19;
    localparam int QW   = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wren_pulse = 1'b0, wrdis_pulse = 1'b0, swr_pulse = 1'b0;
    logic [7:0]    swr_data = 8'h00;
    logic          swr_one_byte = 1'b1, wp_n = 1'b1, op_busy = 1'b0, op_done = 1'b0;
    logic [QW-1:0] query_addr = '0;
    logic [7:0]    status_byte;
    logic          addr_protected, chip_erase_ok;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    flash_status_protect #(.ADDR_W(AW), .QADDR_W(QW), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst(rst), .wren_pulse(wren_pulse), .wrdis_pulse(wrdis_pulse),
        .swr_pulse(swr_pulse), .swr_data(swr_data), .swr_one_byte(swr_one_byte),
        .wp_n(wp_n), .op_busy(op_busy), .op_done(op_done), .query_addr(query_addr),
        .status_byte(status_byte), .addr_protected(addr_protected),
        .chip_erase_ok(chip_erase_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            summary();
        end
    end

    // one-cycle command pulses, driven and released at falling edges
    task automatic p_wren();  @(negedge clk) wren_pulse = 1; @(negedge clk) wren_pulse = 0; endtask
    task automatic p_wrdis(); @(negedge clk) wrdis_pulse = 1; @(negedge clk) wrdis_pulse = 0; endtask
    task automatic p_done();  @(negedge clk) op_done = 1; @(negedge clk) op_done = 0; endtask
    task automatic p_swr(input logic [7:0] d, input logic one);
        @(negedge clk) begin swr_pulse = 1; swr_data = d; swr_one_byte = one; end
        @(negedge clk) begin swr_pulse = 0; swr_one_byte = 1; end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < BUSY + 4 && status_byte[0]; i++) @(negedge clk);
    endtask

    function automatic logic exp_prot(input logic tb, input logic [2:0] lvl, input int a);
        int size;
        if (lvl == 3'd0) return 1'b0;
        if (lvl[2]) return 1'b1;
        size = 1 << (15 + lvl);             // 1/8, 1/4, 1/2 of 2^19
        if (tb) return a < size;
        return a >= (1 << AW) - size;
    endfunction

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status_byte, 8'h00);
        chk("R1 erase ok", chip_erase_ok, 1);
        query_addr = 24'h07FFFF; #1;
        chk("R1 protected", addr_protected, 0);

        // R3 latch set/clear
        p_wren();  chk("R3 set", status_byte, 8'h02);
        p_wrdis(); chk("R3 clear", status_byte, 8'h00);
        @(negedge clk) begin wren_pulse = 1; wrdis_pulse = 1; end
        @(negedge clk) begin wren_pulse = 0; wrdis_pulse = 0; end
        chk("R3 disable wins", status_byte, 8'h00);

        // R4 completion clear
        p_wren(); p_done();
        chk("R4 done clears", status_byte, 8'h00);
        @(negedge clk) begin wren_pulse = 1; op_done = 1; end
        @(negedge clk) begin wren_pulse = 0; op_done = 0; end
        chk("R4 done beats set", status_byte, 8'h00);

        // R2 external busy
        op_busy = 1; #1;
        chk("R2 busy bit", status_byte, 8'h01);
        op_busy = 0; #1;
        chk("R2 busy released", status_byte, 8'h00);

        // R5 rejections
        p_swr(8'h1C, 1);
        chk("R5 no wen", status_byte, 8'h00);
        p_wren();
        p_swr(8'h1C, 0);
        chk("R5 multi-byte rejected", status_byte, 8'h02);
        op_busy = 1;
        p_swr(8'h1C, 1);
        chk("R5 busy rejected", status_byte, 8'h03);
        op_busy = 0;
        @(negedge clk);

        // R6/R7 accepted write of all ones
        p_swr(8'hFF, 1);
        chk("R6 loaded", status_byte, 8'hBF);
        hi = 1;
        for (int i = 0; i < BUSY + 3; i++) begin
            @(negedge clk);
            if (status_byte[0]) hi++;
        end
        chk("R7 busy length", hi, BUSY);
        chk("R7 wen cleared", status_byte, 8'hBC);
        chk("R11 erase blocked", chip_erase_ok, 0);
        query_addr = 24'h000000; #1;
        chk("R10 full protect", addr_protected, 1);

        // R5 lock with pin low, then pin high
        wp_n = 0;
        p_wren();
        p_swr(8'h00, 1);
        chk("R5 locked", status_byte, 8'hBE);
        wp_n = 1;
        p_swr(8'h00, 1);
        wait_idle();
        chk("R5 pin high unlocks", status_byte, 8'h00);

        // R8 R9 R10 R11 R12 sweep over every level/bottom combination
        for (int c = 0; c < 16; c++) begin
            logic tb;
            logic [2:0] lvl;
            tb = c[3];
            lvl = c[2:0];
            p_wren();
            p_swr({2'b00, tb, lvl, 2'b00}, 1);
            wait_idle();
            chk("R2 fields", status_byte, {24'h0, 2'b00, tb, lvl, 2'b00});
            chk("R11 erase flag", chip_erase_ok, lvl == 3'd0);
            for (int a = 0; a < (1 << AW); a += 4096) begin
                for (int k = 0; k < 2; k++) begin
                    int ad;
                    ad = a + k * 4095;
                    query_addr = QW'(ad); #1;
                    chk(tb ? "R9 region" : "R8 region", addr_protected, exp_prot(tb, lvl, ad));
                    query_addr = QW'(ad) | 24'hA80000; #1;
                    chk("R12 upper bits", addr_protected, exp_prot(tb, lvl, ad));
                    if (lvl == 3'd0 || lvl[2])
                        chk("R10 extremes", addr_protected, lvl[2]);
                end
            end
        end
        summary();
    end
endmodule